// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Receiver (Host Side)

This block is the host end of a peripheral-to-host parallel port link. It works in two modes: a four-bit status nibble mode and an eight-bit data-bus byte mode. The host raises and lowers a request line to pace the peripheral. It samples the peripheral's strobe and either the status nibble or the data bus, and it builds whole bytes. Each byte is handed on over a valid/ready output.

When idle, the block keeps its request line low. It waits for the peripheral's data-available interrupt: the available line is low while the peripheral strobe rises. The block acknowledges by raising its request line. It then waits for the peripheral's confirmation line to go low before it starts the transfer.

In nibble mode a byte takes two handshakes, and the low half arrives first. In byte mode a byte takes one handshake, and the host first releases its own data-bus drivers. A secondary host strobe pulses low during each data take. A watchdog ends any handshake that stalls.

Top module: `revrx`

## Requirements
- R1: After reset the request line `hreq_n_o` is low, the host strobe `hstb_n_o` is high, `bus_oe_o` is high, and `out_valid_o` and `wd_err_o` are low.
- R2: In idle, a rising edge on `pstb_n_i` while `pavail_n_i` is low drives `hreq_n_o` high on the next clock. A rising edge while `pavail_n_i` is high is ignored, and `hreq_n_o` stays low.
- R3: After the interrupt acknowledge, the block waits for `pconf_n_i` low. It then drives `hreq_n_o` low to request data, and takes data only when `pstb_n_i` is low while `hreq_n_o` is low.
- R4: In nibble mode (`mode_byte_i`=0) the byte is assembled from two nibble handshakes. The first `stat_i` value becomes bits 3:0 and the second becomes bits 7:4. Between the handshakes `hreq_n_o` goes high and then low again.
- R5: In byte mode (`mode_byte_i`=1) `bus_oe_o` is low before `hreq_n_o` falls to request data. The byte is taken from `bus_i` in one handshake, and `bus_oe_o` is back high once the byte is delivered.
- R6: `hstb_n_o` falls only in the cycle in which `hreq_n_o` rises to take data. It is high in every cycle in which `hreq_n_o` falls.
- R7: Each completed byte is offered on `out_data_o` with `out_valid_o` high. The byte and the valid stay stable until `out_ready_i` is high, and exactly one accepted transfer occurs per byte.
- R8: While a delivered byte has not been accepted, `hreq_n_o` stays high at the data-request step. The request is issued only after acceptance.
- R9: If `pstb_n_i` does not change for `WD_LIMIT` cycles during a handshake, the block returns to idle (`hreq_n_o` low, `hstb_n_o` high, `bus_oe_o` high). It pulses `wd_err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_byte_i | input | 1 | 1 = byte mode, 0 = nibble mode; static during a transfer |
| pstb_n_i | input | 1 | Peripheral strobe, low = data valid |
| pavail_n_i | input | 1 | Peripheral data-available, active low |
| pconf_n_i | input | 1 | Peripheral confirmation of the interrupt acknowledge, active low |
| stat_i | input | NIB_W | Status nibble from the peripheral |
| bus_i | input | 2*NIB_W | Data bus as seen by the host |
| hreq_n_o | output | 1 | Host request line, low = host can accept |
| hstb_n_o | output | 1 | Host strobe, pulses low while data is taken |
| bus_oe_o | output | 1 | Host data-bus driver enable |
| out_valid_o | output | 1 | Received byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 2*NIB_W | Received byte |
| wd_err_o | output | 1 | One-cycle pulse on a watchdog abort |

## Verification
Some properties are checked on every clock. The host strobe must fall only with a rising request and be high whenever the request falls. The output byte must hold while it waits for ready. A pending byte must keep the request high. The bus must be released during a byte-mode request. An abort must leave the idle output levels.

Other behaviour only the bench's scenarios show. These are the nibble order and the value carried for every byte in both modes, the interrupt being ignored while available is high, the count of accepted bytes, and the watchdog's timing window and recovery.

// File: rtl/revrx_pkg.sv
package revrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IRQ,
        ST_REQ_LO,
        ST_TAKE_LO,
        ST_REQ_HI,
        ST_TAKE_HI
    } rx_state_e;

    typedef struct packed {
        rx_state_e st;
        logic      hreq_n;
        logic      hstb_n;
        logic      oe;
        logic      ack_prev;
        logic      err;
    } rx_regs_t;

endpackage

// File: rtl/revrx_watchdog.sv
module revrx_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic strobe_n,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          prev_q;
    logic          changed;

    always_comb begin
        changed = (strobe_n != prev_q);
        expire  = arm && (cnt_q == CW'(LIMIT));
        cnt_d   = (arm && !changed && !expire) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prev_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            prev_q <= strobe_n;
        end
    end
endmodule

// File: rtl/revrx_assemble.sv
module revrx_assemble #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_lo,
    input  logic               cap_hi,
    input  logic               cap_all,
    input  logic [NIB_W-1:0]   nib_i,
    input  logic [2*NIB_W-1:0] bus_i,
    input  logic               deliver,
    input  logic               ready,
    output logic               valid,
    output logic [2*NIB_W-1:0] data
);
    logic [2*NIB_W-1:0] data_d, data_q;
    logic               valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (cap_all) data_d = bus_i;
        if (cap_lo)  data_d[NIB_W-1:0] = nib_i;
        if (cap_hi)  data_d[2*NIB_W-1:NIB_W] = nib_i;
        if (valid_q && ready) valid_d = 1'b0;
        if (deliver) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
endmodule

// File: rtl/revrx.sv
module revrx
    import revrx_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int WD_LIMIT = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_byte_i,
    input  logic               pstb_n_i,
    input  logic               pavail_n_i,
    input  logic               pconf_n_i,
    input  logic [NIB_W-1:0]   stat_i,
    input  logic [2*NIB_W-1:0] bus_i,
    output logic               hreq_n_o,
    output logic               hstb_n_o,
    output logic               bus_oe_o,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [2*NIB_W-1:0] out_data_o,
    output logic               wd_err_o
);
    localparam int BYTE_W = 2 * NIB_W;

    rx_regs_t  r_d, r_q;
    rx_state_e cur_st;
    logic      cap_lo, cap_hi, cap_all, deliver;
    logic      wd_arm, wd_expire;
    logic      out_valid;
    logic [BYTE_W-1:0] out_data;

    assign wd_arm = ((r_q.st == ST_REQ_LO) && !r_q.hreq_n) ||
                    (r_q.st == ST_TAKE_LO) || (r_q.st == ST_REQ_HI) ||
                    (r_q.st == ST_TAKE_HI);

    revrx_watchdog #(.LIMIT(WD_LIMIT)) i_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (wd_arm),
        .strobe_n (pstb_n_i),
        .expire   (wd_expire)
    );

    revrx_assemble #(.NIB_W(NIB_W)) i_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .cap_all (cap_all),
        .nib_i   (stat_i),
        .bus_i   (bus_i),
        .deliver (deliver),
        .ready   (out_ready_i),
        .valid   (out_valid),
        .data    (out_data)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ack_prev = pstb_n_i;
        r_d.err      = 1'b0;
        cap_lo       = 1'b0;
        cap_hi       = 1'b0;
        cap_all      = 1'b0;
        deliver      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.hreq_n = 1'b0;
                r_d.hstb_n = 1'b1;
                r_d.oe     = 1'b1;
                // interrupt: available low while the peripheral strobe rises
                if (!r_q.ack_prev && pstb_n_i && !pavail_n_i) begin
                    r_d.st     = ST_IRQ;
                    r_d.hreq_n = 1'b1;
                end
            end
            ST_IRQ: begin
                if (!pconf_n_i) begin
                    r_d.st = ST_REQ_LO;
                    r_d.oe = !mode_byte_i;
                end
            end
            ST_REQ_LO: begin
                // hold the request back while the last byte waits for ready
                r_d.hreq_n = out_valid;
                if (!r_q.hreq_n && !pstb_n_i) begin
                    cap_lo     = !mode_byte_i;
                    cap_all    = mode_byte_i;
                    r_d.hreq_n = 1'b1;
                    r_d.hstb_n = 1'b0;
                    r_d.st     = ST_TAKE_LO;
                end
            end
            ST_TAKE_LO: begin
                if (pstb_n_i) begin
                    r_d.hstb_n = 1'b1;
                    r_d.hreq_n = 1'b0;
                    if (mode_byte_i) begin
                        deliver = 1'b1;
                        r_d.oe  = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st  = ST_REQ_HI;
                    end
                end
            end
            ST_REQ_HI: begin
                if (!r_q.hreq_n && !pstb_n_i) begin
                    cap_hi     = 1'b1;
                    r_d.hreq_n = 1'b1;
                    r_d.hstb_n = 1'b0;
                    r_d.st     = ST_TAKE_HI;
                end
            end
            ST_TAKE_HI: begin
                if (pstb_n_i) begin
                    deliver    = 1'b1;
                    r_d.hstb_n = 1'b1;
                    r_d.hreq_n = 1'b0;
                    r_d.st     = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (wd_expire) begin
            r_d.st     = ST_IDLE;
            r_d.hreq_n = 1'b0;
            r_d.hstb_n = 1'b1;
            r_d.oe     = 1'b1;
            r_d.err    = 1'b1;
            cap_lo     = 1'b0;
            cap_hi     = 1'b0;
            cap_all    = 1'b0;
            deliver    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.hreq_n   <= 1'b0;
            r_q.hstb_n   <= 1'b1;
            r_q.oe       <= 1'b1;
            r_q.ack_prev <= 1'b1;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_st      = r_q.st;
    assign hreq_n_o    = r_q.hreq_n;
    assign hstb_n_o    = r_q.hstb_n;
    assign bus_oe_o    = r_q.oe;
    assign wd_err_o    = r_q.err;
    assign out_valid_o = out_valid;
    assign out_data_o  = out_data;
endmodule

// File: rtl/revrx_checker.sv
module revrx_checker
    import revrx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_byte,
    input logic              hreq_n,
    input logic              hstb_n,
    input logic              bus_oe,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              wd_err,
    input rx_state_e         st
);
    assert_stb_with_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hstb_n) |-> $rose(hreq_n));

    assert_stb_high_on_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hreq_n) |-> hstb_n);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st == ST_REQ_LO) |=> hreq_n);

    assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && st == ST_REQ_LO && !hreq_n) |-> !bus_oe);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_err |-> (!hreq_n && hstb_n && bus_oe && st == ST_IDLE));
endmodule

bind revrx revrx_checker #(.BYTE_W(2 * NIB_W)) i_revrx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_byte (mode_byte_i),
    .hreq_n    (hreq_n_o),
    .hstb_n    (hstb_n_o),
    .bus_oe    (bus_oe_o),
    .out_valid (out_valid_o),
    .out_ready (out_ready_i),
    .out_data  (out_data_o),
    .wd_err    (wd_err_o),
    .st        (cur_st)
);

// File: tb/test_revrx.sv
module test_revrx;
    localparam int WD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_byte = 1'b0;
    logic       pstb_n = 1'b1;
    logic       pavail_n = 1'b1;
    logic       pconf_n = 1'b1;
    logic [3:0] stat = 4'h0;
    logic [7:0] pbus = 8'h00;
    logic       out_ready = 1'b1;
    logic       hreq_n, hstb_n, bus_oe, out_valid, wd_err;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_acc = 0;
    int n_bytes = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    revrx #(.NIB_W(4), .WD_LIMIT(WD)) i_revrx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_byte_i (mode_byte),
        .pstb_n_i    (pstb_n),
        .pavail_n_i  (pavail_n),
        .pconf_n_i   (pconf_n),
        .stat_i      (stat),
        .bus_i       (pbus),
        .hreq_n_o    (hreq_n),
        .hstb_n_o    (hstb_n),
        .bus_oe_o    (bus_oe),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .wd_err_o    (wd_err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (out_valid && out_ready) n_acc <= n_acc + 1;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_req(input logic lvl, input string tag);
        int k = 0;
        while (hreq_n !== lvl && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (hreq_n !== lvl) check(1'b0, tag, int'(hreq_n), int'(lvl));
    endtask

    task automatic irq_phase();
        @(negedge clk); pavail_n = 1'b0; pstb_n = 1'b0;
        @(negedge clk);
        @(negedge clk); pstb_n = 1'b1;
        @(negedge clk);
        check(hreq_n == 1'b1, "R2 irq acknowledged", int'(hreq_n), 1);
        pconf_n = 1'b0;
    endtask

    task automatic data_phase(input logic [7:0] b);
        int k;
        wait_req(1'b0, "R3 request low");
        check(hstb_n == 1'b1, "R6 strobe high at request", int'(hstb_n), 1);
        if (mode_byte) begin
            check(bus_oe == 1'b0, "R5 bus released", int'(bus_oe), 0);
            pbus = b;
        end else begin
            stat = b[3:0];
        end
        pstb_n = 1'b0;
        wait_req(1'b1, "R3 take first");
        check(hstb_n == 1'b0, "R6 strobe low at take", int'(hstb_n), 0);
        pstb_n = 1'b1;
        if (!mode_byte) begin
            wait_req(1'b0, "R4 second request");
            check(hstb_n == 1'b1, "R6 strobe high at second request", int'(hstb_n), 1);
            stat = b[7:4];
            pstb_n = 1'b0;
            wait_req(1'b1, "R4 take second");
            pstb_n = 1'b1;
        end
        k = 0;
        while (!out_valid && k < 50) begin
            @(negedge clk);
            k++;
        end
        n_bytes++;
        check(out_valid && out_data == b,
              mode_byte ? "R5 byte value" : "R4 nibble order value",
              int'(out_data), int'(b));
        if (mode_byte) check(bus_oe == 1'b1, "R5 bus re-enabled", int'(bus_oe), 1);
        pavail_n = 1'b1;
        pconf_n  = 1'b1;
        stat     = ~b[3:0];
        pbus     = ~b;
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hreq_n == 0 && hstb_n == 1 && bus_oe == 1 && !out_valid && !wd_err,
              "R1 reset state", {hreq_n, hstb_n, bus_oe, out_valid, wd_err}, 5'b01100);

        // strobe pulse with available high must be ignored
        pstb_n = 1'b0;
        @(negedge clk);
        @(negedge clk); pstb_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(hreq_n == 1'b0, "R2 ignored without available", int'(hreq_n), 0);
        end

        // nibble mode sweep over every byte value
        mode_byte = 1'b0;
        for (int v = 0; v < 256; v++) begin
            irq_phase();
            data_phase(8'(v));
            @(negedge clk);
        end

        // byte mode sweep over every byte value
        mode_byte = 1'b1;
        for (int v = 0; v < 256; v++) begin
            irq_phase();
            data_phase(8'(255 - v));
            @(negedge clk);
        end

        // backpressure in both modes
        for (int m = 0; m < 2; m++) begin
            mode_byte = m[0];
            out_ready = 1'b0;
            irq_phase();
            data_phase(8'hA5);
            irq_phase();
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                check(hreq_n == 1'b1, "R8 request held while pending", int'(hreq_n), 1);
                check(out_valid && out_data == 8'hA5, "R7 output held",
                      int'(out_data), 8'hA5);
            end
            out_ready = 1'b1;
            @(negedge clk);
            check(!out_valid, "R7 valid cleared after accept", int'(out_valid), 0);
            data_phase(8'h3C);
            @(negedge clk);
        end

        // watchdog: request issued, peripheral never answers
        mode_byte = 1'b0;
        irq_phase();
        wait_req(1'b0, "R9 request before stall");
        t = 0;
        while (!wd_err && t < 100) begin
            @(negedge clk);
            t++;
        end
        check(wd_err && t >= WD && t <= WD + 4, "R9 abort window", t, WD + 1);
        check(hreq_n == 0 && hstb_n == 1 && bus_oe == 1, "R9 idle after abort",
              {hreq_n, hstb_n, bus_oe}, 3'b011);
        @(negedge clk);
        check(!wd_err, "R9 error is a pulse", int'(wd_err), 0);
        pavail_n = 1'b1;
        pconf_n  = 1'b1;
        @(negedge clk);
        irq_phase();
        data_phase(8'h5A);
        repeat (3) @(negedge clk);

        check(n_acc == n_bytes, "R7 one accept per byte", n_acc, n_bytes);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule